// File: doc/BRIEF.md
# Bus-Invert Transition Encoder

This block sits at both ends of a parallel data link and lowers the number of wires that switch per transfer. On the transmit side, each accepted data word is compared with the value currently on the bus, including one extra polarity line. If sending the word as it is would flip more than half of all lines, the encoder drives the complement of the word and raises the polarity line. Otherwise it drives the word unchanged with the polarity line low. The decision bounds the number of line changes per transfer. For random traffic it removes up to roughly a quarter of the average toggles.

On the receive side, a combinational decoder XORs every bus line with the polarity line to recover the original word. A registered count of the lines that changed on the most recent transfer is provided for checking.

Top module: `bus_invert_codec`

## Requirements
- R1: After synchronous reset, `bus_data` is all zeros, `bus_inv` is 0 and `toggle_cnt` is 0. The encoded link is DATA_W+1 lines wide (N = 9 by default).
- R2: On a cycle with `in_valid` high, let t be popcount(`in_data` XOR current `bus_data`) plus the current `bus_inv`. If 2t > N, the next `bus_inv` is 1. If 2t < N, it is 0. On 2t = N, which can only occur for an odd DATA_W, it keeps its current value.
- R3: When `bus_inv` is 1 after a transfer, `bus_data` holds the bitwise complement of the accepted word. When it is 0, `bus_data` holds the accepted word unchanged.
- R4: The comparison uses the driven bus value, not the previous raw word. Example: after reset, the words 0x0F, 0xF0 and 0x0F give the bus states (0x0F, 0), (0x0F, 1) and (0x0F, 0).
- R5: After each transfer, `toggle_cnt` equals the number of lines, polarity line included, whose value changed on that transfer.
- R6: `toggle_cnt` never exceeds ceil(N/2), which is 5 by default.
- R7: `dec_data` equals `bus_data` XOR the replicated `bus_inv`, with no register in the path. After every transfer it equals the accepted word.
- R8: On cycles with `in_valid` low, `bus_data`, `bus_inv` and `toggle_cnt` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_data` for a transfer this cycle |
| in_data | input | DATA_W | Word to be sent |
| bus_data | output | DATA_W | Encoded data lines as driven |
| bus_inv | output | 1 | Polarity line (1 = data lines carry the complement) |
| toggle_cnt | output | CNT_W | Lines changed on the last transfer |
| dec_data | output | DATA_W | Word recovered by the receive-side decoder |

## Verification
The assertions assume that `in_valid` and `in_data` are known (never X) at every clock edge once reset is released. They also assume that a transfer in the first cycle after reset starts from the all-zero bus. The bench changes inputs only on the falling edge and holds them steady through the rising edge. It starts each run from a completed reset and applies a second reset partway through. The stimulus includes idle cycles with arbitrary data on `in_data`, to confirm that words offered without `in_valid` leave no mark.

// File: rtl/bus_invert_pkg.sv
package bus_invert_pkg;

    typedef enum logic {
        POL_PLAIN  = 1'b0,
        POL_INVERT = 1'b1
    } polarity_e;

    // Width needed to hold a count of 0..lines
    function automatic int unsigned count_width(input int unsigned lines);
        return $clog2(lines + 1);
    endfunction

endpackage

// File: rtl/bi_popcount.sv
module bi_popcount #(
    parameter int W  = 9,
    parameter int CW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bi_polarity_select.sv
module bi_polarity_select
    import bus_invert_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CW     = 4
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] bus_q,
    input  logic              inv_q,
    output polarity_e         pol,
    output logic [DATA_W-1:0] bus_next
);
    localparam int            LINES   = DATA_W + 1;
    localparam logic [CW:0]   LINES_V = (CW+1)'(LINES);

    logic [CW-1:0] data_flips;
    logic [CW-1:0] plain_cost;
    logic [CW:0]   plain_twice;

    bi_popcount #(.W(DATA_W), .CW(CW)) u_diff_cnt (
        .vec  (word ^ bus_q),
        .ones (data_flips)
    );

    // Cost of sending plain: data flips plus polarity line falling if high
    assign plain_cost  = data_flips + CW'(inv_q);
    assign plain_twice = {plain_cost, 1'b0};

    always_comb begin
        if (plain_twice > LINES_V) begin
            pol = POL_INVERT;
        end else if (plain_twice == LINES_V) begin
            pol = polarity_e'(inv_q);
        end else begin
            pol = POL_PLAIN;
        end
    end

    assign bus_next = (pol == POL_INVERT) ? ~word : word;
endmodule

// File: rtl/bi_line_register.sv
module bi_line_register
    import bus_invert_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_next,
    input  polarity_e         pol_next,
    output logic [DATA_W-1:0] bus_q,
    output logic              inv_q,
    output logic [CW-1:0]     flips_q
);
    localparam int LINES = DATA_W + 1;

    logic [LINES-1:0] line_next;
    logic [LINES-1:0] line_q;
    logic [CW-1:0]    flips_next;

    assign line_next = {bus_next, pol_next == POL_INVERT};
    assign line_q    = {bus_q, inv_q};

    bi_popcount #(.W(LINES), .CW(CW)) u_flip_cnt (
        .vec  (line_next ^ line_q),
        .ones (flips_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q   <= '0;
            inv_q   <= 1'b0;
            flips_q <= '0;
        end else if (load) begin
            bus_q   <= bus_next;
            inv_q   <= (pol_next == POL_INVERT);
            flips_q <= flips_next;
        end
    end
endmodule

// File: rtl/bi_decoder.sv
module bi_decoder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] bus_word,
    input  logic              bus_pol,
    output logic [DATA_W-1:0] word
);
    assign word = bus_word ^ {DATA_W{bus_pol}};
endmodule

// File: rtl/bus_invert_codec.sv
module bus_invert_codec
    import bus_invert_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_inv,
    output logic [CNT_W-1:0]  toggle_cnt,
    output logic [DATA_W-1:0] dec_data
);
    polarity_e         pol_sel;
    logic [DATA_W-1:0] bus_next;

    bi_polarity_select #(.DATA_W(DATA_W), .CW(CNT_W)) u_select (
        .word     (in_data),
        .bus_q    (bus_data),
        .inv_q    (bus_inv),
        .pol      (pol_sel),
        .bus_next (bus_next)
    );

    bi_line_register #(.DATA_W(DATA_W), .CW(CNT_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .bus_next (bus_next),
        .pol_next (pol_sel),
        .bus_q    (bus_data),
        .inv_q    (bus_inv),
        .flips_q  (toggle_cnt)
    );

    bi_decoder #(.DATA_W(DATA_W)) u_decode (
        .bus_word (bus_data),
        .bus_pol  (bus_inv),
        .word     (dec_data)
    );
endmodule

// File: rtl/bus_invert_codec_chk.sv
module bus_invert_codec_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_inv,
    input logic [CNT_W-1:0]  toggle_cnt,
    input logic [DATA_W-1:0] dec_data
);
    localparam int LINES = DATA_W + 1;
    localparam int CAP   = (LINES + 1) / 2;

    // R6
    toggle_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(toggle_cnt) <= CAP);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(bus_data) && $stable(bus_inv) && $stable(toggle_cnt)));

    // R7
    decode_match_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dec_data == $past(in_data)));

    // R3
    polarity_data_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (bus_data == (bus_inv ? ~$past(in_data) : $past(in_data))));

    // R5
    flip_count_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (int'(toggle_cnt) ==
            $countones({bus_data, bus_inv} ^ $past({bus_data, bus_inv}))));
endmodule

bind bus_invert_codec bus_invert_codec_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .bus_data   (bus_data),
    .bus_inv    (bus_inv),
    .toggle_cnt (toggle_cnt),
    .dec_data   (dec_data)
);

// File: tb/bus_invert_codec_tb.sv
module bus_invert_codec_tb;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;
    localparam int LINES  = DATA_W + 1;
    localparam int NVEC   = 16;

    // {valid, data}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1FF, 9'h100, 9'h1F0, 9'h10F, 9'h0AA, 9'h1AA, 9'h155, 9'h1FF,
        9'h1FE, 9'h001, 9'h101, 9'h1C3, 9'h13C, 9'h180, 9'h17F, 9'h1FF
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [DATA_W-1:0] bus_data;
    logic              bus_inv;
    logic [CNT_W-1:0]  toggle_cnt;
    logic [DATA_W-1:0] dec_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic [DATA_W-1:0] m_bus  = '0;
    logic              m_inv  = 1'b0;
    int                m_cnt  = 0;
    logic [DATA_W-1:0] m_word = '0;

    always #5 clk = ~clk;

    bus_invert_codec #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .bus_data   (bus_data),
        .bus_inv    (bus_inv),
        .toggle_cnt (toggle_cnt),
        .dec_data   (dec_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [LINES-1:0] v);
        int n = 0;
        for (int i = 0; i < LINES; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic model_step(input logic v, input logic [DATA_W-1:0] d);
        if (v) begin
            int t;
            logic [DATA_W-1:0] nb;
            logic ni;
            t = ones({1'b0, d ^ m_bus}) + int'(m_inv);
            if (2 * t > LINES)       ni = 1'b1;
            else if (2 * t < LINES)  ni = 1'b0;
            else                     ni = m_inv;
            nb = ni ? ~d : d;
            m_cnt  = ones({nb, ni} ^ {m_bus, m_inv});
            m_bus  = nb;
            m_inv  = ni;
            m_word = d;
        end
    endtask

    task automatic drive(input logic v, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #2;
        model_step(v, d);
    endtask

    task automatic check_all();
        chk("R2 polarity",     32'(bus_inv),    32'(m_inv));
        chk("R3 data lines",   32'(bus_data),   32'(m_bus));
        chk("R5 toggle count", 32'(toggle_cnt), 32'(m_cnt));
        chk("R6 toggle cap",   32'(int'(toggle_cnt) <= (LINES + 1) / 2), 32'd1);
        chk("R7 decode",       32'(dec_data),   32'(m_word));
    endtask

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] hb;
        logic hi;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 reset bus",    32'(bus_data),   32'h0);
        chk("R1 reset inv",    32'(bus_inv),    32'h0);
        chk("R1 reset count",  32'(toggle_cnt), 32'h0);

        // table walk (R2 R3 R5 R6 R7, with idle rows for R8)
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][8], VEC[k][7:0]);
            check_all();
        end

        // R8: idle cycles with changing data leave everything untouched
        hb = bus_data;
        hi = bus_inv;
        for (int k = 0; k < 3; k++) begin
            drive(1'b0, DATA_W'(8'h5A + k * 8'h33));
            chk("R8 idle bus",   32'(bus_data),   32'(hb));
            chk("R8 idle inv",   32'(bus_inv),    32'(hi));
            chk("R8 idle count", 32'(toggle_cnt), 32'(m_cnt));
        end

        // R1: reset partway through
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_bus = '0; m_inv = 1'b0; m_cnt = 0; m_word = '0;
        #1;
        chk("R1 mid reset bus", 32'(bus_data), 32'h0);
        chk("R1 mid reset inv", 32'(bus_inv),  32'h0);
        chk("R1 mid reset cnt", 32'(toggle_cnt), 32'h0);

        // R4: hand-computed sequence against the driven value
        drive(1'b1, 8'h0F);
        chk("R4 step1 bus", 32'(bus_data), 32'h0F);
        chk("R4 step1 inv", 32'(bus_inv),  32'h0);
        chk("R5 step1 cnt", 32'(toggle_cnt), 32'd4);
        drive(1'b1, 8'hF0);
        chk("R4 step2 bus", 32'(bus_data), 32'h0F);
        chk("R4 step2 inv", 32'(bus_inv),  32'h1);
        chk("R5 step2 cnt", 32'(toggle_cnt), 32'd1);
        chk("R7 step2 dec", 32'(dec_data), 32'hF0);
        drive(1'b1, 8'h0F);
        chk("R4 step3 bus", 32'(bus_data), 32'h0F);
        chk("R4 step3 inv", 32'(bus_inv),  32'h0);
        chk("R5 step3 cnt", 32'(toggle_cnt), 32'd1);

        // R2 boundary: 4 data flips with polarity low stays plain (2*4 < 9)
        drive(1'b1, 8'hFF);
        chk("R2 four flips inv", 32'(bus_inv),  32'h0);
        chk("R2 four flips bus", 32'(bus_data), 32'hFF);
        // R2 boundary: 5 data flips with polarity low inverts
        drive(1'b1, 8'h07);
        chk("R2 five flips inv", 32'(bus_inv),  32'h1);
        chk("R3 five flips bus", 32'(bus_data), 32'hF8);
        chk("R6 five flips cnt", 32'(toggle_cnt), 32'd4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule